// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures the frequency of an intermediate-frequency signal by counting its rising edges over a known gate window. The window is timed by a slow timebase tick, for example a 1 kHz pulse derived from the crystal. A level-sensitive start input controls each measurement, and a 2-bit code picks the gate length. The IF input is asynchronous. A synchroniser brings it into the system clock domain, and its rising edges are detected there.

A measurement begins on a 0-to-1 change of `start`. The block then waits a few ticks so that the input can settle. Next it opens the gate and counts edges into an accumulator. When the gate closes, the block freezes the result and raises `done`. The result stays on `count` for as long as `start` stays high. Lowering `start` clears the result and the flag, so software must read `count` before it drops `start`.

As a worked example, a 32-tick gate at 1 kHz that collects 342400 edges gives 342400 / 32 ms = 10.7 MHz. The result and `done` are plain level outputs. They have no handshake and no back-pressure: the result is simply held until `start` falls.

Top module: `if_freq_counter`

## Requirements
- R1: After reset, `count` is 0 and `done` is 0.
- R2: The gate code selects the gate length, counted in ticks: 00 gives 4, 01 gives 8, 10 gives 32 and 11 gives 64. The result equals the number of IF rising edges whose detected pulse falls inside the gate.
- R3: Before the gate opens, the block waits 4 ticks for codes 00 and 01 and 8 ticks for codes 10 and 11. Only ticks sampled after the cycle in which the start rise is sampled are counted. `done` rises in the cycle after the tick that ends the gate.
- R4: While `start` is 0, `count` is 0 and `done` is 0, from the cycle after `start` is sampled low.
- R5: Once `done` is 1, `count` stays constant and `done` stays 1 for as long as `start` remains 1, even if IF edges and ticks keep arriving.
- R6: The count saturates at all ones (2^CNT_W-1) and does not wrap.
- R7: The gate code is captured on the start rise. A change of `gate_sel` during a measurement has no effect on its timing.
- R8: Lowering `start` in the middle of a measurement aborts it. The next rise of `start` begins a fresh measurement from a count of zero.
- R9: `done` is 0 from the start rise until the gate ends. The count changes by at most one per clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase pulse, one clock cycle wide |
| start | input | 1 | Level-sensitive start; 0 clears, a rising edge begins a measurement |
| gate_sel | input | 2 | Gate-length code, captured on the start rise |
| if_in | input | 1 | Asynchronous IF signal to be counted |
| count | output | CNT_W | Measured edge count, held while `start` is 1 |
| done | output | 1 | High when the gate has closed and `count` is final |

## Verification
The hardest condition to reach is saturation. With the default 20-bit width, the counter needs more than a million counted edges, and the synchroniser can detect at most one edge every two clocks. The bench therefore builds the block with a 10-bit accumulator. It drives the IF input at the fastest rate the synchroniser can follow, across a long gate with a slow tick, so the true edge count overshoots the width. The exact cycles at which the gate opens and closes depend on the tick phase at the start rise. The bench works these cycles out arithmetically from the tick period, so that every gate code is checked against an edge count that is exact to the cycle.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_GATE = 2'd2,
    ST_HOLD = 2'd3
  } ifc_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ifc_sync_edge.sv
module ifc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);

  logic [STAGES-1:0] chain;
  logic              last_q;

  // Synchroniser chain of STAGES flops
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];
  end

  assign rise_pulse = chain[STAGES-1] & ~last_q;

endmodule

// File: rtl/ifc_sequencer.sv
module ifc_sequencer
  import ifc_pkg::*;
#(
  parameter int GATE0  = 4,
  parameter int GATE1  = 8,
  parameter int GATE2  = 32,
  parameter int GATE3  = 64,
  parameter int WAIT_S = 4,
  parameter int WAIT_L = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start,
  input  logic [1:0] gate_sel,
  output logic       gate_open,
  output logic       clear,
  output logic       done
);

  localparam int MAXLEN = imax(imax(imax(GATE0, GATE1), imax(GATE2, GATE3)),
                               imax(WAIT_S, WAIT_L));
  localparam int TCW    = $clog2(MAXLEN + 1);

  ifc_state_e     state_q;
  logic           start_q;
  logic [1:0]     code_q;
  logic [TCW-1:0] tcnt_q;
  logic [TCW-1:0] wait_last;
  logic [TCW-1:0] gate_last;

  // Last tick index of each phase for the captured code
  always_comb begin
    unique case (code_q)
      2'd0:    gate_last = TCW'(GATE0 - 1);
      2'd1:    gate_last = TCW'(GATE1 - 1);
      2'd2:    gate_last = TCW'(GATE2 - 1);
      default: gate_last = TCW'(GATE3 - 1);
    endcase
    wait_last = code_q[1] ? TCW'(WAIT_L - 1) : TCW'(WAIT_S - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
      code_q  <= 2'd0;
      tcnt_q  <= '0;
    end else begin
      start_q <= start;
      if (!start) begin
        state_q <= ST_IDLE;
        tcnt_q  <= '0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (!start_q) begin
              state_q <= ST_WAIT;
              code_q  <= gate_sel;
              tcnt_q  <= '0;
            end
          end
          ST_WAIT: begin
            if (tick) begin
              if (tcnt_q == wait_last) begin
                state_q <= ST_GATE;
                tcnt_q  <= '0;
              end else begin
                tcnt_q <= tcnt_q + 1'b1;
              end
            end
          end
          ST_GATE: begin
            if (tick) begin
              if (tcnt_q == gate_last) begin
                state_q <= ST_HOLD;
                tcnt_q  <= '0;
              end else begin
                tcnt_q <= tcnt_q + 1'b1;
              end
            end
          end
          default: state_q <= ST_HOLD;
        endcase
      end
    end
  end

  assign gate_open = (state_q == ST_GATE);
  assign clear     = (state_q == ST_IDLE) | ~start;
  assign done      = (state_q == ST_HOLD);

endmodule

// File: rtl/ifc_accum.sv
module ifc_accum #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             enable,
  input  logic             pulse,
  output logic [CNT_W-1:0] value
);

  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      value <= '0;
    end else if (enable && pulse && (value != FULL)) begin
      value <= value + 1'b1;
    end
  end

endmodule

// File: rtl/if_freq_counter.sv
module if_freq_counter #(
  parameter int CNT_W       = 20,
  parameter int SYNC_STAGES = 2,
  parameter int GATE0       = 4,
  parameter int GATE1       = 8,
  parameter int GATE2       = 32,
  parameter int GATE3       = 64,
  parameter int WAIT_S      = 4,
  parameter int WAIT_L      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic [1:0]       gate_sel,
  input  logic             if_in,
  output logic [CNT_W-1:0] count,
  output logic             done
);

  logic edge_p;
  logic gate_open;
  logic clr;

  ifc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .async_in   (if_in),
    .rise_pulse (edge_p)
  );

  ifc_sequencer #(
    .GATE0(GATE0), .GATE1(GATE1), .GATE2(GATE2), .GATE3(GATE3),
    .WAIT_S(WAIT_S), .WAIT_L(WAIT_L)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .start     (start),
    .gate_sel  (gate_sel),
    .gate_open (gate_open),
    .clear     (clr),
    .done      (done)
  );

  ifc_accum #(.CNT_W(CNT_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clr),
    .enable (gate_open),
    .pulse  (edge_p),
    .value  (count)
  );

endmodule

// File: rtl/ifc_checker.sv
module ifc_checker #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             start,
  input logic [CNT_W-1:0] count,
  input logic             done
);

  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  assert_idle_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (count == '0 && !done));

  assert_hold_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> ($stable(count) && done));

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL && start) |=> (count == FULL));

  assert_done_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(tick));

  assert_step_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (count == $past(count) || count == $past(count) + 1'b1));

endmodule

bind if_freq_counter ifc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .tick  (tick),
  .start (start),
  .count (count),
  .done  (done)
);

// File: tb/tb_if_freq_counter.sv
module tb_if_freq_counter;

  localparam int CW   = 10;
  localparam int FULL = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    gate_sel = 2'd0;
  logic          if_in = 1'b0;
  logic [CW-1:0] count;
  logic          done;

  int cyc = 0;
  int td = 10;
  int per = 2;
  int ph = 0;
  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  if_freq_counter #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
    .gate_sel(gate_sel), .if_in(if_in), .count(count), .done(done)
  );

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // Drive values that will be sampled at posedge number cyc+1
  always @(negedge clk) begin
    tick  <= ((cyc + 1) % td) == 0;
    if_in <= ((cyc + 1 + ph) % per) < (per / 2);
  end

  function automatic bit lvl(int n);
    return ((n + ph) % per) < (per / 2);
  endfunction

  function automatic int exp_cnt(int a, int b);
    int c = 0;
    for (int n = a; n <= b; n++) if (lvl(n) && !lvl(n - 1)) c++;
    return (c > FULL) ? FULL : c;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_until(int n);
    while (cyc < n) @(negedge clk);
  endtask

  // Full measurement; sel_late != code tests R7
  task automatic measure(int code, int sel_late, string req);
    int s, first, wl, gl, tst, tend, e, held;
    start = 1'b0;
    repeat (3) @(negedge clk);
    gate_sel = code[1:0];
    start = 1'b1;
    s = cyc + 1;
    @(negedge clk);
    gate_sel = sel_late[1:0];
    wl = (code >= 2) ? 8 : 4;
    gl = (code == 0) ? 4 : (code == 1) ? 8 : (code == 2) ? 32 : 64;
    first = (s / td + 1) * td;
    tst = first + (wl - 1) * td;
    tend = tst + gl * td;
    e = exp_cnt(tst - 1, tend - 2);
    wait_until(tend - 1);
    chk(done == 1'b0, "R9 done low before gate end", done, 0);
    @(negedge clk);
    chk(done == 1'b1, {req, " R3 done at gate end"}, done, 1);
    chk(count == e, {req, " R2 count"}, count, e);
    held = count;
    repeat (3 * td) @(negedge clk);
    chk(count == held && done, "R5 result held", count, held);
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int e;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(count == 0 && !done, "R1 reset state", count, 0);

    // Sweep of gate codes, IF periods and phases
    for (int c = 0; c < 4; c++)
      for (int p = 2; p <= 7; p++)
        for (int f = 0; f < 2; f++) begin
          per = p; ph = f;
          measure(c, c, "R2 sweep");
        end

    // R4: clearing after completion
    start = 1'b0;
    @(negedge clk);
    chk(count == 0 && !done, "R4 clear on start low", count, 0);

    // R7: code changed after start is ignored
    per = 3; ph = 0;
    measure(0, 3, "R7 late code 0->3");
    measure(2, 1, "R7 late code 2->1");

    // R8: abort mid-gate then fresh run
    per = 2;
    start = 1'b0;
    repeat (2) @(negedge clk);
    gate_sel = 2'd1;
    start = 1'b1;
    repeat (9 * td) @(negedge clk);
    chk(count != 0, "R8 counting before abort", count, 1);
    start = 1'b0;
    @(negedge clk);
    chk(count == 0 && !done, "R8 abort clears", count, 0);
    measure(1, 1, "R8 restart");

    // R6: saturation with slow tick and fastest IF
    td = 40; per = 2; ph = 1;
    @(negedge clk);
    e = exp_cnt(1, 64 * 40);
    chk(e == FULL, "R6 stimulus overshoots width", e, FULL);
    measure(3, 3, "R6 saturate");
    chk(count == FULL, "R6 saturated value", count, FULL);

    start = 1'b0;
    @(negedge clk);
    chk(count == 0 && !done, "R4 clear after saturation", count, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule